// File: doc/BRIEF.md
# Four-Channel Countdown Timer

This block is a register-mapped timer with a set of independent down-counters, four by default, each intended to serve one processor core. Software programs a channel through its own 64-byte register window: it chooses a run mode, sets a load value, copies that value into the counter, and starts the counter. When the counter expires, the channel latches a pending flag and, if its mask allows, raises its own interrupt line. In free-running mode the counter refills itself and keeps going. In one-shot mode it stops.

Pending flags are acknowledged through a per-channel clear register. An acknowledge is not instantaneous. It occupies a fixed window of several cycles, and a readable busy bit shows that window. Further acknowledge writes are refused while busy is set, and an expiry that lands inside the window is kept rather than wiped. A summary of every channel's pending flag is available only in channel 0's window.

The bus is an APB-style port with no wait states. A write commits on the clock edge where `psel`, `penable` and `pwrite` are all high. Read data is a combinational function of `paddr` and has no side effects.

Top module: `tmr_quad`

## Requirements
- R1: After reset, every channel reads mode 0, load 0, enable 0, count 0, pending 0, clear-busy 0 and mask 1, and all interrupt outputs are low.
- R2: Channel n occupies addresses n*0x40 to n*0x40+0x3F. Within a window, 0x04 bit 0 is the mode (0 free-running, 1 one-shot), 0x08 is the load value, 0x10 bit 0 is the enable and 0x24 bit 0 is the mask, and each reads back what was written. Offset 0x14 and all offsets without a register read 0.
- R3: While enabled with a nonzero count, the counter decreases by exactly one per clock, and offset 0x18 returns the live count.
- R4: An enabled channel whose count is 0 expires on the next edge and sets its pending flag. In free-running mode the counter is refilled from the load value on that edge, so the period is load+1 cycles.
- R5: When a one-shot channel expires, its enable reads 0 and its count stays at 0.
- R6: Any write to offset 0x14 copies the load value into the counter, whatever data is written.
- R7: At channel 0's offset 0x00, bit n reads channel n's pending flag. Offset 0x00 of any other channel reads 0.
- R8: At offset 0x20, bit 0 reads the pending flag and bit 1 reads the busy bit. Writing 0 to bit 0 changes nothing. Writing 1 to bit 0 while not busy sets busy for exactly 3 cycles, and pending then drops at the edge that ends busy.
- R9: A write of 1 to offset 0x20 while busy is set is ignored and does not lengthen the busy window.
- R10: An expiry that occurs during the busy window leaves the pending flag set after the window ends.
- R11: Interrupt line n is high exactly when channel n is pending and its mask bit is 0.
- R12: Activity on one channel leaves the count of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase; a write commits when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | 8 | Byte address; upper 2 bits select the channel, lower 6 the offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| irq | output | 4 | One interrupt line per channel |

## Verification
A counter that is off by one shows up in the very next read of offset 0x18. A wrong reload source or a wrong period appears as a pending flag that rises one or more cycles away from load+1 edges after enable. Errors in the acknowledge window show through the busy bit, which must read 1 in exactly three consecutive samples, and through the pending bit after the window. A timeout dropped inside the window leaves pending reading 0 on the first cycle after busy falls. A status bit or interrupt routed to the wrong channel is exposed at once, because only one channel is pending when the summary word and the irq lines are sampled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int WIN_BITS = 6;

    localparam logic [WIN_BITS-1:0] OFF_STAT = 6'h00;
    localparam logic [WIN_BITS-1:0] OFF_CTRL = 6'h04;
    localparam logic [WIN_BITS-1:0] OFF_LOAD = 6'h08;
    localparam logic [WIN_BITS-1:0] OFF_EN   = 6'h10;
    localparam logic [WIN_BITS-1:0] OFF_RELD = 6'h14;
    localparam logic [WIN_BITS-1:0] OFF_VAL  = 6'h18;
    localparam logic [WIN_BITS-1:0] OFF_CLR  = 6'h20;
    localparam logic [WIN_BITS-1:0] OFF_MASK = 6'h24;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_ONCE = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic ctrl;
        logic load;
        logic en;
        logic reld;
        logic clr;
        logic mask;
    } chan_wr_t;

    function automatic chan_wr_t decode_wr(input logic [WIN_BITS-1:0] off);
        chan_wr_t s;
        s      = '0;
        s.ctrl = (off == OFF_CTRL);
        s.load = (off == OFF_LOAD);
        s.en   = (off == OFF_EN);
        s.reld = (off == OFF_RELD);
        s.clr  = (off == OFF_CLR);
        s.mask = (off == OFF_MASK);
        return s;
    endfunction

endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int ADDR_W = CH_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output chan_wr_t          wr [NUM_CH]
);

    logic                hit;
    logic [CH_W-1:0]     ch;
    logic [WIN_BITS-1:0] off;
    chan_wr_t            dec;

    assign hit = psel && penable && pwrite;
    assign ch  = paddr[ADDR_W-1:WIN_BITS];
    assign off = paddr[WIN_BITS-1:0];
    assign dec = decode_wr(off);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign wr[g] = (hit && ch == CH_W'(g)) ? dec : '0;

        // R2: a single write reaches at most one register of one channel
        a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
            $onehot0(wr[g]));
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int CLR_CYCLES = 3,
    localparam int BW        = $clog2(CLR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_wr_t         wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             mode_o,
    output logic [CNT_W-1:0] load_o,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o,
    output logic             busy_o,
    output logic             mask_o,
    output logic             irq_o
);

    run_mode_e        mode_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             pend_q;
    logic             mask_q;
    logic [BW-1:0]    clr_q;
    logic             caught_q;

    logic timeout;
    logic busy;
    logic start_clr;
    logic finish;

    assign timeout   = en_q && (cnt_q == '0);
    assign busy      = (clr_q != '0);
    assign start_clr = wr.clr && wdata[0] && !busy;
    assign finish    = (clr_q == BW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_FREE;
            load_q   <= '0;
            cnt_q    <= '0;
            en_q     <= 1'b0;
            pend_q   <= 1'b0;
            mask_q   <= 1'b1;
            clr_q    <= '0;
            caught_q <= 1'b0;
        end else begin
            if (wr.ctrl) mode_q <= run_mode_e'(wdata[0]);
            if (wr.load) load_q <= wdata;
            if (wr.mask) mask_q <= wdata[0];

            if (wr.reld)
                cnt_q <= load_q;
            else if (timeout)
                cnt_q <= (mode_q == MODE_FREE) ? load_q : '0;
            else if (en_q)
                cnt_q <= cnt_q - 1'b1;

            if (wr.en)
                en_q <= wdata[0];
            else if (timeout && mode_q == MODE_ONCE)
                en_q <= 1'b0;

            if (start_clr)
                clr_q <= BW'(CLR_CYCLES);
            else if (busy)
                clr_q <= clr_q - 1'b1;

            if (finish)
                caught_q <= 1'b0;
            else if ((busy || start_clr) && timeout)
                caught_q <= 1'b1;

            if (timeout)
                pend_q <= 1'b1;
            else if (finish && !caught_q)
                pend_q <= 1'b0;
        end
    end

    assign mode_o = mode_q;
    assign load_o = load_q;
    assign en_o   = en_q;
    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;
    assign busy_o = busy;
    assign mask_o = mask_q;
    assign irq_o  = pend_q && !mask_q;

    // R3: one step down per cycle while running
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (en_q && !timeout && !wr.reld) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R4: an expiry always leaves the channel pending
    a_r4_pend_on_timeout: assert property (@(posedge clk) disable iff (rst)
        timeout |=> pend_q);

    // R5: one-shot expiry stops the channel
    a_r5_once_stops: assert property (@(posedge clk) disable iff (rst)
        (timeout && mode_q == MODE_ONCE && !wr.en && !wr.reld) |=> (!en_q && cnt_q == '0));

    // R8: a clean acknowledge drops pending when busy ends
    a_r8_drop: assert property (@(posedge clk) disable iff (rst)
        (finish && !caught_q && !timeout) |=> (!pend_o && !busy_o));

    // R9: a write while busy does not restart the window
    a_r9_no_extend: assert property (@(posedge clk) disable iff (rst)
        (busy && wr.clr) |=> clr_q == $past(clr_q) - 1'b1);

    // R10: an expiry caught inside the window survives it
    a_r10_keep: assert property (@(posedge clk) disable iff (rst)
        (finish && caught_q) |=> pend_o);

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int CH_W   = 2,
    parameter int ADDR_W = CH_W + WIN_BITS
) (
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [NUM_CH-1:0]             mode,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  load,
    input  logic [NUM_CH-1:0]             en,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
    input  logic [NUM_CH-1:0]             pend,
    input  logic [NUM_CH-1:0]             busy,
    input  logic [NUM_CH-1:0]             mask,
    output logic [CNT_W-1:0]              prdata
);

    logic [CH_W-1:0]     ch;
    logic [WIN_BITS-1:0] off;
    logic                ch_ok;
    logic [CNT_W-1:0]    stat_word;

    assign ch    = paddr[ADDR_W-1:WIN_BITS];
    assign off   = paddr[WIN_BITS-1:0];
    assign ch_ok = (int'(ch) < NUM_CH);

    always_comb begin
        stat_word = '0;
        stat_word[NUM_CH-1:0] = pend;
    end

    always_comb begin
        prdata = '0;
        if (ch_ok) begin
            case (off)
                OFF_STAT: prdata = (ch == '0) ? stat_word : '0;
                OFF_CTRL: prdata = CNT_W'(mode[ch]);
                OFF_LOAD: prdata = load[ch];
                OFF_EN:   prdata = CNT_W'(en[ch]);
                OFF_VAL:  prdata = cnt[ch];
                OFF_CLR:  prdata = CNT_W'({busy[ch], pend[ch]});
                OFF_MASK: prdata = CNT_W'(mask[ch]);
                default:  prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
    import tmr_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int CNT_W      = 32,
    parameter int CLR_CYCLES = 3,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W    = CH_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic [NUM_CH-1:0] irq
);

    chan_wr_t                    wr [NUM_CH];
    logic [NUM_CH-1:0]           mode, en, pend, busy, mask;
    logic [NUM_CH-1:0][CNT_W-1:0] load, cnt;

    tmr_bus_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) i_dec (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .wr(wr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_chan #(.CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) i_chan (
            .clk(clk), .rst(rst), .wr(wr[g]), .wdata(pwdata),
            .mode_o(mode[g]), .load_o(load[g]), .en_o(en[g]), .cnt_o(cnt[g]),
            .pend_o(pend[g]), .busy_o(busy[g]), .mask_o(mask[g]), .irq_o(irq[g])
        );

        // R11: an interrupt line never fires without its channel pending and unmasked
        a_r11_irq_src: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> (pend[g] && !mask[g]));

        // R12: a channel that is idle and not addressed keeps its count
        a_r12_isolated: assert property (@(posedge clk) disable iff (rst)
            (!en[g] && !wr[g].reld) |=> $stable(cnt[g]));
    end

    tmr_rd_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W), .ADDR_W(ADDR_W)) i_rd (
        .paddr(paddr), .mode(mode), .load(load), .en(en), .cnt(cnt),
        .pend(pend), .busy(busy), .mask(mask), .prdata(prdata)
    );

endmodule

// File: tb/test_tmr_quad.sv
module test_tmr_quad;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tmr_quad i_tmr_quad (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    function automatic logic [7:0] adr(input int ch, input logic [5:0] off);
        return {2'(ch), off};
    endfunction

    // expected live count k cycles after enable in free-running mode
    function automatic logic [31:0] exp_count(input int l, input int k);
        return 32'((k % (l + 1) == 0) ? l : l - (k % (l + 1)));
    endfunction

    function automatic logic [31:0] exp_clr(input bit busy, input bit pend);
        return {30'd0, busy, pend};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        paddr = a; pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        paddr = a; pwrite = 1'b0; psel = 1'b1; penable = 1'b1;
        #1 d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, other0;
        int c, o, l;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int ch = 0; ch < NCH; ch++) begin
            rd(adr(ch, 6'h04), v); chk("R1 mode", v, 0);
            rd(adr(ch, 6'h08), v); chk("R1 load", v, 0);
            rd(adr(ch, 6'h10), v); chk("R1 enable", v, 0);
            rd(adr(ch, 6'h18), v); chk("R1 count", v, 0);
            rd(adr(ch, 6'h20), v); chk("R1 clear reg", v, 0);
            rd(adr(ch, 6'h24), v); chk("R1 mask", v, 1);
        end
        rd(adr(0, 6'h00), v); chk("R1 status", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R3 R4 R6 R12 free-running periods with random loads
        for (int it = 0; it < 3; it++) begin
            c = it + 1;
            o = (c + 1) % NCH;
            l = 3 + int'($urandom_range(0, 20));
            wr(adr(c, 6'h08), 32'(l));
            wr(adr(c, 6'h14), $urandom);             // R6 any data
            rd(adr(c, 6'h18), v); chk("R6 reload copies load", v, 32'(l));
            wr(adr(c, 6'h04), 32'd0);
            rd(adr(o, 6'h18), other0);
            wr(adr(c, 6'h10), 32'd1);
            for (int k = 0; k <= 2 * l + 2; k++) begin
                rd(adr(c, 6'h18), v); chk("R3 live count", v, exp_count(l, k));
                rd(adr(c, 6'h20), v);
                if (k == l)     chk("R4 not yet pending", v[0], 0);
                if (k == l + 1) chk("R4 pending at load+1", v[0], 1);
                @(negedge clk);
            end
            rd(adr(o, 6'h18), v); chk("R12 other channel count", v, other0);
            wr(adr(c, 6'h10), 32'd0);
            wr(adr(c, 6'h20), 32'd1);
            repeat (4) @(negedge clk);
            rd(adr(c, 6'h20), v); chk("R8 cleared", v, exp_clr(0, 0));
        end

        // channel 2 pending again via one-shot expiry, R5
        c = 2;
        wr(adr(c, 6'h04), 32'd1);
        wr(adr(c, 6'h08), 32'd2);
        wr(adr(c, 6'h14), 32'd0);
        wr(adr(c, 6'h10), 32'd1);
        repeat (6) @(negedge clk);
        rd(adr(c, 6'h10), v); chk("R5 enable self-clears", v, 0);
        rd(adr(c, 6'h18), v); chk("R5 count held at 0", v, 0);
        rd(adr(c, 6'h20), v); chk("R4 one-shot pending", v, exp_clr(0, 1));

        // R11 mask gating
        chk("R11 masked irq low", 32'(irq[c]), 0);
        wr(adr(c, 6'h24), 32'd0);
        chk("R11 unmasked irq high", 32'(irq), 32'h4);

        // R7 status summary
        rd(adr(0, 6'h00), v); chk("R7 status ch0 window", v, 32'h4);
        rd(adr(c, 6'h00), v); chk("R7 status other window", v, 0);

        // R8 R9 acknowledge handshake
        wr(adr(c, 6'h20), 32'd0);
        rd(adr(c, 6'h20), v); chk("R8 write 0 no effect", v, exp_clr(0, 1));
        wr(adr(c, 6'h20), 32'd1);
        rd(adr(c, 6'h20), v); chk("R8 busy cycle 1", v, exp_clr(1, 1));
        wr(adr(c, 6'h20), 32'd1);
        rd(adr(c, 6'h20), v); chk("R9 busy cycle 2", v, exp_clr(1, 1));
        @(negedge clk);
        rd(adr(c, 6'h20), v); chk("R8 busy cycle 3", v, exp_clr(1, 1));
        @(negedge clk);
        rd(adr(c, 6'h20), v); chk("R9 window not extended", v, exp_clr(0, 0));
        chk("R11 irq drops", 32'(irq), 0);

        // R10 expiry inside the window
        c = 3;
        wr(adr(c, 6'h04), 32'd1);
        wr(adr(c, 6'h08), 32'd1);
        wr(adr(c, 6'h14), 32'd0);
        wr(adr(c, 6'h10), 32'd1);
        wr(adr(c, 6'h20), 32'd1);
        rd(adr(c, 6'h20), v); chk("R10 busy before expiry", v, exp_clr(1, 0));
        @(negedge clk);
        rd(adr(c, 6'h20), v); chk("R10 expiry in window", v, exp_clr(1, 1));
        repeat (2) @(negedge clk);
        rd(adr(c, 6'h20), v); chk("R10 pending survives", v, exp_clr(0, 1));

        // R2 random readback and unmapped offsets
        for (int it = 0; it < 24; it++) begin
            logic [31:0] ld;
            logic md, mk;
            c  = int'($urandom_range(0, 3));
            ld = $urandom;
            md = 1'($urandom);
            mk = 1'($urandom);
            wr(adr(c, 6'h08), ld);
            wr(adr(c, 6'h04), {31'd0, md});
            wr(adr(c, 6'h24), {31'd0, mk});
            rd(adr(c, 6'h08), v); chk("R2 load readback", v, ld);
            rd(adr(c, 6'h04), v); chk("R2 mode readback", v, 32'(md));
            rd(adr(c, 6'h24), v); chk("R2 mask readback", v, 32'(mk));
        end
        wr(adr(1, 6'h10), 32'd1);
        rd(adr(1, 6'h10), v); chk("R2 enable readback", v[0], 1);
        wr(adr(1, 6'h10), 32'd0);
        rd(adr(1, 6'h0C), v); chk("R2 unmapped 0x0C", v, 0);
        rd(adr(2, 6'h3C), v); chk("R2 unmapped 0x3C", v, 0);
        rd(adr(0, 6'h14), v); chk("R2 reload reads 0", v, 0);

        finish_run();
    end

endmodule